// File: doc/BRIEF.md
# Keyed Overlay Selector with Colour Lookup Table

This block chooses, pixel by pixel, what the video encoder and the RGB output stage receive. The main stream is 24-bit YCbCr. An overlay source supplies a 3-bit code for every pixel. That code picks one of eight programmable YCbCr colours. A key input decides for each active pixel whether the main pixel or the overlay colour is used. The key's active level is set by a configuration bit.

There are two output paths: one for the composite/S-video encoder and one for the RGB stage. A configuration bit can stop the key from acting on the encoder path. In that case the overlay is seen only on the RGB path. A second configuration bit turns on a test pattern. The pattern reads the eight table colours in order across the active line as eight bars of equal width. It needs no external data. Outside active video, both paths carry black-level blanking. Both paths are registered once, so they have the same one-cycle latency.

Top module: `key_overlay_mux`

## Requirements
- R1: While reset is high, and in the first output after it, both output paths hold blanking: Y=16, Cb=128, Cr=128, packed as {Y[23:16], Cb[15:8], Cr[7:0]}.
- R2: When `pix_active` is low, both paths output blanking one cycle later, whatever the key, the overlay code and the mode bits are.
- R3: On an active pixel that is not keyed, with bar mode off, both paths output the main pixel one cycle later.
- R4: On a keyed active pixel, with bar mode off, the RGB path outputs table entry `ovl_code` one cycle later. The encoder path does the same when `cfg_enc_key_en` is 1.
- R5: A pixel is keyed when `key_in` equals `cfg_key_pol`: 1 means the key is active high, 0 means active low.
- R6: When `cfg_enc_key_en` is 0, the encoder path outputs the main pixel while the RGB path still shows the overlay for keyed pixels.
- R7: A write (`lut_we`, 3-bit `lut_addr`, 24-bit `lut_wdata` in the R1 packing) updates one table entry. The pixel sampled in the same cycle still sees the old value. The next pixel sees the new one.
- R8: With `cfg_bar_en` set, active pixel p (p=0 on the `line_start` pixel) outputs entry min(p / (LINE_W/8), 7) on both paths. The key, the overlay code and the main pixel have no effect.
- R9: `line_start` restarts the bar sequence at entry 0, including in the middle of a line.
- R10: Bar mode is entered only through `cfg_bar_en`. With it clear, `line_start` does not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_active | input | 1 | Current pixel lies in active video |
| line_start | input | 1 | Pulse on the first active pixel of a line |
| main_ycc | input | 24 | Main stream pixel {Y,Cb,Cr} |
| key_in | input | 1 | Per-pixel overlay key |
| ovl_code | input | 3 | Overlay colour index |
| cfg_key_pol | input | 1 | Key active level |
| cfg_enc_key_en | input | 1 | Allow keying on encoder path |
| cfg_bar_en | input | 1 | Colour bar test pattern enable |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 3 | Table write index |
| lut_wdata | input | 24 | Table write data {Y,Cb,Cr} |
| enc_ycc | output | 24 | Pixel to composite/S-video encoder |
| rgb_ycc | output | 24 | Pixel to RGB output stage |

## Verification
Some behaviours are checked by the assertions on every cycle:
- blanking outside active video;
- the pass-through of unkeyed main pixels on the RGB path;
- the main pixel on the encoder path when keying there is off;
- matching paths in bar mode;
- bar index steps that are either +1 or a restart.

Other behaviours are shown only by the bench scenarios:
- which table entry a given code or bar position selects;
- the cycle in which a table write becomes visible;
- where bars fall inside a line and where they restart.

// File: rtl/kov_pkg.sv
package kov_pkg;

    localparam int NUM_COLOURS = 8;
    localparam int IDX_W       = $clog2(NUM_COLOURS);
    localparam int PIX_W       = 24;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    localparam ycc_t BLANK_YCC = '{y: 8'd16, cb: 8'd128, cr: 8'd128};

    typedef enum logic [1:0] {
        SRC_BLANK = 2'd0,
        SRC_MAIN  = 2'd1,
        SRC_OVL   = 2'd2,
        SRC_BAR   = 2'd3
    } src_e;

    function automatic logic is_keyed(input logic key, input logic pol);
        return key == pol;
    endfunction

    function automatic ycc_t pick(input src_e s, input ycc_t main_px,
                                  input ycc_t ovl_px, input ycc_t bar_px);
        case (s)
            SRC_MAIN: return main_px;
            SRC_OVL:  return ovl_px;
            SRC_BAR:  return bar_px;
            default:  return BLANK_YCC;
        endcase
    endfunction

endpackage

// File: rtl/kov_lut.sv
module kov_lut
    import kov_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ycc_t             wr_val,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ycc_t             rd_a_val,
    output ycc_t             rd_b_val
);

    ycc_t entry_q [NUM_COLOURS];

    for (genvar g = 0; g < NUM_COLOURS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= BLANK_YCC;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_val;
            end
        end
    end

    assign rd_a_val = entry_q[rd_a_idx];
    assign rd_b_val = entry_q[rd_b_idx];

    // R7: a written entry holds the written value in the following cycle
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> entry_q[$past(wr_idx)] == $past(wr_val));

endmodule

// File: rtl/kov_bar_gen.sv
module kov_bar_gen
    import kov_pkg::*;
#(
    parameter int LINE_W = 720
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_active,
    input  logic             line_start,
    output logic [IDX_W-1:0] bar_idx
);

    localparam int BAR_LEN = (LINE_W / NUM_COLOURS) < 1 ? 1 : (LINE_W / NUM_COLOURS);
    localparam int CNT_W   = $clog2(BAR_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_BAR = IDX_W'(NUM_COLOURS - 1);

    logic [CNT_W-1:0] cnt_q, cur_cnt;
    logic [IDX_W-1:0] bar_q, cur_bar;

    always_comb begin
        cur_cnt = line_start ? '0 : cnt_q;
        cur_bar = line_start ? '0 : bar_q;
    end

    assign bar_idx = cur_bar;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bar_q <= '0;
        end else if (pix_active) begin
            if (cur_cnt == CNT_W'(BAR_LEN - 1)) begin
                cnt_q <= '0;
                bar_q <= (cur_bar == LAST_BAR) ? LAST_BAR : cur_bar + 1'b1;
            end else begin
                cnt_q <= cur_cnt + 1'b1;
                bar_q <= cur_bar;
            end
        end else if (line_start) begin
            cnt_q <= '0;
            bar_q <= '0;
        end
    end

    // R8: the bar index only holds, steps by one, or restarts on line_start
    a_r8_bar_step: assert property (@(posedge clk) disable iff (rst)
        !$past(line_start) |->
            (bar_q == $past(bar_q)) || (bar_q == $past(bar_q) + 1'b1));

    // R9: an active line_start pixel leaves the counter in bar 0 or bar 1
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        (line_start && pix_active) |=> bar_q == ((BAR_LEN == 1) ? IDX_W'(1) : IDX_W'(0)));

endmodule

// File: rtl/key_overlay_mux.sv
module key_overlay_mux
    import kov_pkg::*;
#(
    parameter int LINE_W = 720
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pix_active,
    input  logic        line_start,
    input  logic [23:0] main_ycc,
    input  logic        key_in,
    input  logic [2:0]  ovl_code,
    input  logic        cfg_key_pol,
    input  logic        cfg_enc_key_en,
    input  logic        cfg_bar_en,
    input  logic        lut_we,
    input  logic [2:0]  lut_addr,
    input  logic [23:0] lut_wdata,
    output logic [23:0] enc_ycc,
    output logic [23:0] rgb_ycc
);

    ycc_t             ovl_val, bar_val, enc_d, rgb_d, enc_q, rgb_q;
    logic [IDX_W-1:0] bar_idx;
    src_e             enc_src, rgb_src;
    logic             keyed;

    kov_lut u_lut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (lut_we),
        .wr_idx   (lut_addr),
        .wr_val   (ycc_t'(lut_wdata)),
        .rd_a_idx (ovl_code),
        .rd_b_idx (bar_idx),
        .rd_a_val (ovl_val),
        .rd_b_val (bar_val)
    );

    kov_bar_gen #(.LINE_W(LINE_W)) u_bar (
        .clk        (clk),
        .rst        (rst),
        .pix_active (pix_active),
        .line_start (line_start),
        .bar_idx    (bar_idx)
    );

    always_comb begin
        keyed = is_keyed(key_in, cfg_key_pol);
        if (!pix_active) begin
            enc_src = SRC_BLANK;
            rgb_src = SRC_BLANK;
        end else if (cfg_bar_en) begin
            enc_src = SRC_BAR;
            rgb_src = SRC_BAR;
        end else begin
            rgb_src = keyed ? SRC_OVL : SRC_MAIN;
            enc_src = (keyed && cfg_enc_key_en) ? SRC_OVL : SRC_MAIN;
        end
        enc_d = pick(enc_src, ycc_t'(main_ycc), ovl_val, bar_val);
        rgb_d = pick(rgb_src, ycc_t'(main_ycc), ovl_val, bar_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q <= BLANK_YCC;
            rgb_q <= BLANK_YCC;
        end else begin
            enc_q <= enc_d;
            rgb_q <= rgb_d;
        end
    end

    assign enc_ycc = enc_q;
    assign rgb_ycc = rgb_q;

    // R2: both paths blank one cycle after an inactive pixel
    a_r2_blank: assert property (@(posedge clk) disable iff (rst)
        !pix_active |=> (enc_ycc == BLANK_YCC) && (rgb_ycc == BLANK_YCC));

    // R3: an unkeyed active pixel passes through on the RGB path
    a_r3_rgb_pass: assert property (@(posedge clk) disable iff (rst)
        (pix_active && !cfg_bar_en && (key_in != cfg_key_pol)) |=> rgb_ycc == $past(main_ycc));

    // R6: with encoder keying off, the encoder path always carries main video
    a_r6_enc_main: assert property (@(posedge clk) disable iff (rst)
        (pix_active && !cfg_bar_en && !cfg_enc_key_en) |=> enc_ycc == $past(main_ycc));

    // R8: in bar mode both paths carry the same colour
    a_r8_paths_match: assert property (@(posedge clk) disable iff (rst)
        (pix_active && cfg_bar_en) |=> enc_ycc == rgb_ycc);

endmodule

// File: tb/key_overlay_mux_bench.sv
module key_overlay_mux_bench;
    localparam int LINE_W  = 16;
    localparam int BAR_LEN = LINE_W / 8;
    localparam logic [23:0] BLANK = 24'h108080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_active = 1'b0, line_start = 1'b0;
    logic [23:0] main_ycc = '0;
    logic        key_in = 1'b0;
    logic [2:0]  ovl_code = '0;
    logic        cfg_key_pol = 1'b1, cfg_enc_key_en = 1'b1, cfg_bar_en = 1'b0;
    logic        lut_we = 1'b0;
    logic [2:0]  lut_addr = '0;
    logic [23:0] lut_wdata = '0;
    logic [23:0] enc_ycc, rgb_ycc;

    logic [23:0] mdl [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    key_overlay_mux #(.LINE_W(LINE_W)) u_key_overlay_mux (
        .clk(clk), .rst(rst), .pix_active(pix_active), .line_start(line_start),
        .main_ycc(main_ycc), .key_in(key_in), .ovl_code(ovl_code),
        .cfg_key_pol(cfg_key_pol), .cfg_enc_key_en(cfg_enc_key_en),
        .cfg_bar_en(cfg_bar_en), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_wdata(lut_wdata), .enc_ycc(enc_ycc), .rgb_ycc(rgb_ycc)
    );

    function automatic logic [23:0] colour(input int i, input int salt);
        return {8'(16 + i * 29 + salt), 8'(240 - i * 17 + salt), 8'(40 + i * 23 + salt)};
    endfunction

    task automatic chk(input string req, input string path, input logic [23:0] got,
                       input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %06h expected %06h", req, path, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = BLANK;
        step();
        step();
        chk("R1", "enc", enc_ycc, BLANK);
        chk("R1", "rgb", rgb_ycc, BLANK);
        rst = 1'b0;

        // R7: load the table while inactive; R2 blanking throughout
        for (int i = 0; i < 8; i++) begin
            lut_we = 1'b1; lut_addr = 3'(i); lut_wdata = colour(i, 0);
            key_in = 1'b1; ovl_code = 3'(i); cfg_bar_en = 1'(i & 1);
            step();
            mdl[i] = colour(i, 0);
            chk("R2", "enc", enc_ycc, BLANK);
            chk("R2", "rgb", rgb_ycc, BLANK);
        end
        lut_we = 1'b0; cfg_bar_en = 1'b0;

        // R3 R4 R5 R6: sweep polarity, encoder keying, key level and code
        for (int pol = 0; pol < 2; pol++)
            for (int ek = 0; ek < 2; ek++)
                for (int k = 0; k < 2; k++)
                    for (int c = 0; c < 8; c++) begin
                        logic keyed;
                        logic [23:0] m;
                        m = colour(c + k * 8, 7 + pol);
                        pix_active = 1'b1; cfg_key_pol = 1'(pol); cfg_enc_key_en = 1'(ek);
                        key_in = 1'(k); ovl_code = 3'(c); main_ycc = m;
                        line_start = 1'(c == 3);
                        keyed = (k == pol);
                        step();
                        chk(keyed ? "R4_R5" : "R3_R10", "rgb", rgb_ycc, keyed ? mdl[c] : m);
                        chk(keyed ? (ek ? "R4" : "R6") : "R3", "enc", enc_ycc,
                            (keyed && ek) ? mdl[c] : m);
                    end
        line_start = 1'b0;

        // R7: write during a keyed pixel; old value now, new value next pixel
        cfg_key_pol = 1'b1; cfg_enc_key_en = 1'b1; key_in = 1'b1; ovl_code = 3'd3;
        lut_we = 1'b1; lut_addr = 3'd3; lut_wdata = 24'hA1B2C3;
        step();
        chk("R7", "rgb", rgb_ycc, mdl[3]);
        mdl[3] = 24'hA1B2C3;
        lut_we = 1'b0;
        step();
        chk("R7", "rgb", rgb_ycc, mdl[3]);
        chk("R7", "enc", enc_ycc, mdl[3]);

        // R8: colour bars, key and main pixel toggling with no effect
        cfg_bar_en = 1'b1;
        for (int p = 0; p < LINE_W + 4; p++) begin
            int b;
            line_start = 1'(p == 0);
            key_in = 1'(p & 1); ovl_code = 3'(p); main_ycc = colour(p, 3);
            b = (p / BAR_LEN > 7) ? 7 : p / BAR_LEN;
            step();
            chk("R8", "rgb", rgb_ycc, mdl[b]);
            chk("R8", "enc", enc_ycc, mdl[b]);
        end

        // R9: restart part-way through a line
        for (int p = 0; p < 7; p++) begin
            line_start = 1'(p == 0);
            step();
        end
        for (int p = 0; p < 2 * BAR_LEN + 1; p++) begin
            line_start = 1'(p == 0);
            step();
            chk("R9", "rgb", rgb_ycc, mdl[p / BAR_LEN]);
        end
        line_start = 1'b0;

        // R2 within bar mode
        pix_active = 1'b0;
        step();
        chk("R2", "enc", enc_ycc, BLANK);

        done = 1;
        summary();
    end
endmodule